// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host port and an asynchronous 256K x 8 DRAM with a 9-bit multiplexed address. It accepts one request at a time over a valid/ready handshake with an 18-bit word address, in which bits 17:9 select the row and bits 8:0 the column. It turns each request into RAS, CAS, WE and OE strobes and puts the matching half of the address on the 9-bit output. A read returns one byte with a one-cycle `rd_valid` pulse. Every strobe and the address are registered outputs. Every timing window is a whole number of clock cycles, found by rounding up a nanosecond minimum divided by the clock period.

The row stays open after an access. A later request to the same row becomes a column-only cycle. A request to another row, a refresh request, or a page that has been open too long closes the row, and the precharge time runs out before the next row cycle starts. Writes are always early writes: WE is low before CAS falls, so the DRAM never drives the bus during a write and the controller drives the bus only for writes. A refresh requester raises `ref_req` and holds it until it sees `ref_ack`. The controller then finishes its current work, closes the page and runs a CAS-before-RAS refresh.

States: IDLE (row closed), ROW (RAS low, row address), CSET (column address set up, CAS high), COL (CAS low), CPRE (CAS precharge), OPEN (row open, waiting), PRECH (RAS precharge), RFCAS (refresh, CAS low first), RFRAS (refresh, RAS low). Transitions:
- IDLE goes to RFCAS on a refresh request, or to ROW when it accepts a request.
- ROW goes to CSET, CSET to COL, COL to CPRE and CPRE to OPEN, each when its timer expires.
- OPEN goes to CSET when it accepts a same-row request. It goes to PRECH on a refresh request, on page age, or on a request to another row.
- RFCAS goes to RFRAS, RFRAS to PRECH, and PRECH to IDLE, each when its timer expires.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During reset and right after it, `ras_n`, `cas_n`, `we_n` and `oe_n` are 1, and `dq_oe`, `rd_valid` and `ref_ack` are 0. With `ref_req` low, `req_ready` is 1.
- R2: A request accepted with the row closed drives address bits 17:9 on `dram_a` in the cycle RAS falls. Address bits 8:0 are on `dram_a` one cycle before CAS falls and stay there while CAS falls. At default parameters CAS falls exactly 6 cycles after RAS: a 5-cycle row phase that covers both the RAS-to-CAS delay and the RAS access time, plus 1 setup cycle.
- R3: For a read, `oe_n` is low and `dq_oe` is 0 while CAS is low. The byte on `dq_in` is captured at the edge that ends the CAS-low window. `rd_valid` is high for one cycle, in the same cycle that CAS rises, and `rd_data` then holds that byte.
- R4: For a write, `we_n` is low and `dq_oe` is 1 with the write byte on `dq_out` from one cycle before CAS falls until CAS rises, and `oe_n` stays high. Whenever `dq_oe` is 1, `we_n` is 0 and `oe_n` is 1.
- R5: A request to the row that is open is served without a RAS fall: only the CSET, COL and CPRE column phases run.
- R6: A request to a different row closes the page. RAS rises and a new RAS fall carries the new row.
- R7: While RAS is low, each CAS-low window lasts at least 4 cycles at default parameters, which covers both the CAS access time and the column-address access time. CAS stays high for at least 3 cycles between column cycles.
- R8: RAS never stays low for the full page-mode limit of 25000 cycles at default parameters. An open page with no traffic closes itself between 24000 and 24999 cycles after RAS fell.
- R9: While `ref_req` is high, `req_ready` is 0. The open page is closed and a refresh runs with CAS falling while RAS is still high. When the refresh cycle ends, `ref_ack` is high for one cycle with both strobes high, and the row is closed afterwards.
- R10: Every RAS fall, including the one inside a refresh, comes at least 8 cycles after the previous RAS rise at default parameters.
- R11: `req_ready` is 0 whenever a column cycle or row cycle is in progress. It is 1 only in IDLE, or in OPEN for a same-row request when no refresh is pending and the page is not too old.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in 17:9, column in 8:0 |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Read byte |
| ref_req | input | 1 | Refresh request, held until acknowledged |
| ref_ack | output | 1 | One-cycle refresh done pulse |
| dram_a | output | 9 | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | 8 | Data to DRAM |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 8 | Data from DRAM |

## Verification
The assertions check the following on every cycle:
- the precharge gap before each RAS fall;
- the minimum CAS-low width inside a row;
- the page-open bound;
- a stable column address as CAS falls;
- the bus-drive rule for writes;
- `req_ready` never being high during a column cycle;
- the timing of the read and refresh strobes.

Only the bench scenarios can show that data written through the controller comes back at the right address. The same holds for telling page hits from misses, where hits must cause no RAS fall, and for the exact 6-cycle row-to-column spacing. The bench also shows a refresh interrupting an open page and an idle page closing itself before the limit.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ROW, ST_CSET, ST_COL, ST_CPRE,
        ST_OPEN, ST_PRECH, ST_RFCAS, ST_RFRAS
    } fpm_state_e;

    function automatic int cyc_of(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/fpm_dly_cnt.sv
`timescale 1ns/1ps
module fpm_dly_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R7: a loaded window of more than one cycle cannot end at once
    a_r7_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
        load && (load_val != '0) |=> !done);
endmodule

// File: rtl/fpm_page_track.sv
`timescale 1ns/1ps
module fpm_page_track #(
    parameter int ROW_W = 9,
    parameter int LIMIT = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             close_i,
    output logic [ROW_W-1:0] row_o,
    output logic             old_o
);
    localparam int AGE_W = $clog2(LIMIT + 1);

    logic             valid;
    logic [AGE_W-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            age   <= '0;
            row_o <= '0;
        end else if (open_i) begin
            valid <= 1'b1;
            age   <= '0;
            row_o <= row_i;
        end else if (close_i) begin
            valid <= 1'b0;
        end else if (valid && age != '1) begin
            age <= age + 1'b1;
        end
    end

    assign old_o = valid && (age >= AGE_W'(LIMIT));

    // R8: an age flag never appears for a page that was just opened
    a_r8_fresh_page: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |=> !old_o);
endmodule

// File: rtl/fpm_dram_ctrl.sv
`timescale 1ns/1ps
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int CLK_NS   = 4,
    parameter int ROW_W    = 9,
    parameter int DATA_W   = 8,
    parameter int TRP_NS   = 30,
    parameter int TRCD_NS  = 15,
    parameter int TCAC_NS  = 10,
    parameter int TAA_NS   = 20,
    parameter int TRAC_NS  = 40,
    parameter int TCP_NS   = 10,
    parameter int TCSR_NS  = 10,
    parameter int TRAS_NS  = 40,
    parameter int TRASP_NS = 100000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [2*ROW_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  ref_req,
    output logic                  ref_ack,
    output logic [ROW_W-1:0]      dram_a,
    output logic                  ras_n,
    output logic                  cas_n,
    output logic                  we_n,
    output logic                  oe_n,
    output logic [DATA_W-1:0]     dq_out,
    output logic                  dq_oe,
    input  logic [DATA_W-1:0]     dq_in
);
    localparam int ADDR_W   = 2 * ROW_W;
    localparam int TRP_C    = cyc_of(TRP_NS, CLK_NS);
    localparam int TRCD_C   = cyc_of(TRCD_NS, CLK_NS);
    localparam int TCAC_C   = cyc_of(TCAC_NS, CLK_NS);
    localparam int TAA_C    = cyc_of(TAA_NS, CLK_NS);
    localparam int TRAC_C   = cyc_of(TRAC_NS, CLK_NS);
    localparam int TCP_C    = cyc_of(TCP_NS, CLK_NS);
    localparam int TCSR_C   = cyc_of(TCSR_NS, CLK_NS);
    localparam int TRAS_C   = cyc_of(TRAS_NS, CLK_NS);
    localparam int COL_LEN  = imax(TCAC_C, TAA_C - 1);
    localparam int ROW_LEN  = imax(TRCD_C, TRAC_C - 1 - COL_LEN);
    localparam int PAGE_CYC = TRASP_NS / CLK_NS;
    localparam int GUARD    = COL_LEN + TCP_C + 3;
    localparam int DLY_MAX  = imax(imax(ROW_LEN, COL_LEN), imax(imax(TRP_C, TCP_C), imax(TCSR_C, TRAS_C)));
    localparam int DLY_W    = $clog2(DLY_MAX + 1);
    localparam int AGE_W    = $clog2(PAGE_CYC + 1);

    fpm_state_e          state, nxt;
    logic                dly_done, dly_load;
    logic [DLY_W-1:0]    dly_val;
    logic [ROW_W-1:0]    open_row;
    logic                page_old, accept, same_row;
    logic                cur_wr, acc_wr;
    logic [ROW_W-1:0]    cur_col, acc_col;
    logic [DATA_W-1:0]   cur_wd, acc_wd;

    fpm_dly_cnt #(.W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val), .done(dly_done)
    );

    fpm_page_track #(.ROW_W(ROW_W), .LIMIT(PAGE_CYC - GUARD)) u_page (
        .clk(clk), .rst_n(rst_n),
        .open_i(state == ST_IDLE && nxt == ST_ROW),
        .row_i(req_addr[ADDR_W-1:ROW_W]),
        .close_i(nxt == ST_PRECH && state != ST_PRECH),
        .row_o(open_row), .old_o(page_old)
    );

    assign same_row  = (req_addr[ADDR_W-1:ROW_W] == open_row);
    assign req_ready = !ref_req && ((state == ST_IDLE) ||
                       (state == ST_OPEN && !page_old && same_row));
    assign accept    = req_valid && req_ready;
    assign acc_wr    = accept ? req_write : cur_wr;
    assign acc_col   = accept ? req_addr[ROW_W-1:0] : cur_col;
    assign acc_wd    = accept ? req_wdata : cur_wd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (ref_req) nxt = ST_RFCAS;
                      else if (accept) nxt = ST_ROW;
            ST_ROW:   if (dly_done) nxt = ST_CSET;
            ST_CSET:  nxt = ST_COL;
            ST_COL:   if (dly_done) nxt = ST_CPRE;
            ST_CPRE:  if (dly_done) nxt = ST_OPEN;
            ST_OPEN:  if (ref_req || page_old) nxt = ST_PRECH;
                      else if (accept) nxt = ST_CSET;
                      else if (req_valid) nxt = ST_PRECH;
            ST_PRECH: if (dly_done) nxt = ST_IDLE;
            ST_RFCAS: if (dly_done) nxt = ST_RFRAS;
            ST_RFRAS: if (dly_done) nxt = ST_PRECH;
            default:  nxt = ST_IDLE;
        endcase
    end

    // phase length loaded on each state change
    assign dly_load = (nxt != state);
    always_comb begin
        unique case (nxt)
            ST_ROW:   dly_val = DLY_W'(ROW_LEN - 1);
            ST_COL:   dly_val = DLY_W'(COL_LEN - 1);
            ST_CPRE:  dly_val = DLY_W'(TCP_C - 1);
            ST_PRECH: dly_val = DLY_W'(TRP_C - 1);
            ST_RFCAS: dly_val = DLY_W'(TCSR_C - 1);
            ST_RFRAS: dly_val = DLY_W'(TRAS_C - 1);
            default:  dly_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_wr  <= 1'b0;
            cur_col <= '0;
            cur_wd  <= '0;
        end else if (accept) begin
            cur_wr  <= req_write;
            cur_col <= req_addr[ROW_W-1:0];
            cur_wd  <= req_wdata;
        end
    end

    // outputs, registered from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_n    <= 1'b1;
            cas_n    <= 1'b1;
            we_n     <= 1'b1;
            oe_n     <= 1'b1;
            dq_oe    <= 1'b0;
            dq_out   <= '0;
            dram_a   <= '0;
            ref_ack  <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            ras_n    <= !(nxt inside {ST_ROW, ST_CSET, ST_COL, ST_CPRE, ST_OPEN, ST_RFRAS});
            cas_n    <= !(nxt inside {ST_COL, ST_RFCAS, ST_RFRAS});
            we_n     <= !((nxt inside {ST_CSET, ST_COL}) && acc_wr);
            oe_n     <= !(nxt == ST_COL && !acc_wr);
            dq_oe    <= (nxt inside {ST_CSET, ST_COL}) && acc_wr;
            dq_out   <= acc_wd;
            ref_ack  <= (state == ST_RFRAS) && dly_done;
            rd_valid <= (state == ST_COL) && dly_done && !cur_wr;
            if (nxt == ST_ROW)       dram_a <= req_addr[ADDR_W-1:ROW_W];
            else if (nxt == ST_CSET) dram_a <= acc_col;
            if ((state == ST_COL) && dly_done && !cur_wr) rd_data <= dq_in;
        end
    end

    // ---- assertion support: strobe run lengths ----
    logic [DLY_W-1:0] ras_hi_cnt, cas_lo_cnt;
    logic [AGE_W-1:0] ras_lo_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_hi_cnt <= DLY_W'(TRP_C);
            cas_lo_cnt <= '0;
            ras_lo_cnt <= '0;
        end else begin
            ras_hi_cnt <= ras_n ? ((ras_hi_cnt == DLY_W'(TRP_C)) ? ras_hi_cnt : ras_hi_cnt + 1'b1) : '0;
            cas_lo_cnt <= !cas_n ? ((cas_lo_cnt == '1) ? cas_lo_cnt : cas_lo_cnt + 1'b1) : '0;
            ras_lo_cnt <= !ras_n ? ((ras_lo_cnt == '1) ? ras_lo_cnt : ras_lo_cnt + 1'b1) : '0;
        end
    end

    a_r10_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ras_hi_cnt >= DLY_W'(TRP_C));
    a_r7_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) && !ras_n |-> cas_lo_cnt >= DLY_W'(COL_LEN));
    a_r8_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> ras_lo_cnt < AGE_W'(PAGE_CYC));
    a_r2_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) && !ras_n |-> $stable(dram_a));
    a_r4_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !we_n && oe_n);
    a_r11_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cas_n);
    a_r3_rd_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(cas_n) && !ras_n);
    a_r9_ack_close: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> ras_n && cas_n && $past(!cas_n));
endmodule

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  dq_in = '0;
    logic        req_ready, rd_valid, ref_ack, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [7:0]  rd_data, dq_out;
    logic [8:0]  dram_a;

    always #2 clk = ~clk;   // 250 MHz

    fpm_dram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_ack(ref_ack),
        .dram_a(dram_a), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // {write, address, data}; reads expect data
    localparam int NV = 11;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 18'h00005, 8'hA5}, {1'b1, 18'h00006, 8'h3C},
        {1'b0, 18'h00005, 8'hA5}, {1'b0, 18'h00006, 8'h3C},
        {1'b1, 18'h3FE01, 8'h77}, {1'b0, 18'h3FE01, 8'h77},
        {1'b0, 18'h00005, 8'hA5}, {1'b1, 18'h20000, 8'h11},
        {1'b1, 18'h201FF, 8'hEE}, {1'b0, 18'h201FF, 8'hEE},
        {1'b0, 18'h20000, 8'h11}
    };

    int n_chk = 0, n_err = 0, m_chk = 0, m_err = 0, w_err = 0;
    logic [8:0] exp_row = '0, exp_col = '0;
    logic [7:0] exp_wd = '0;
    logic [7:0] mem [logic [17:0]];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mchk(input bit ok, input string tag, input int act, input int exp);
        m_chk++;
        if (!ok) begin
            m_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // DRAM model and strobe monitor, sampled on the falling edge
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, first_cas = 1'b0;
    logic [8:0] p_a = '0, m_row = '0;
    int ras_hi_run = 100, ras_lo_run = 0, cas_lo_run = 0, cas_hi_run = 100, since_ras = 0;
    int ras_falls = 0, cbr_cnt = 0, col_cnt = 0, last_ras_lo = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                mchk(ras_hi_run >= 8, "R10 precharge gap", ras_hi_run, 8);
                if (!cas_n) cbr_cnt++;
                else begin
                    mchk(dram_a == exp_row, "R2 row address", dram_a, exp_row);
                    m_row = dram_a;
                    ras_falls++;
                end
                since_ras = 0;
                first_cas = 1'b1;
            end else if (!ras_n) since_ras++;
            if (!p_ras && ras_n) last_ras_lo = ras_lo_run;
            if (p_cas && !cas_n && !ras_n) begin
                if (first_cas) mchk(since_ras == 6, "R2 ras-to-cas", since_ras, 6);
                else mchk(cas_hi_run >= 3, "R7 cas high", cas_hi_run, 3);
                first_cas = 1'b0;
                mchk(dram_a == exp_col, "R2 column address", dram_a, exp_col);
                mchk(p_a == dram_a, "R2 column setup", p_a, dram_a);
                if (!we_n) begin
                    mchk(!p_we && dq_oe && oe_n && dq_out == exp_wd, "R4 early write", dq_out, exp_wd);
                    mem[{m_row, dram_a}] = dq_out;
                end else begin
                    mchk(!dq_oe && !oe_n, "R3 read drive", {dq_oe, oe_n}, 0);
                    dq_in = mem.exists({m_row, dram_a}) ? mem[{m_row, dram_a}] : 8'h00;
                end
            end
            if (!p_cas && cas_n && !p_ras) begin
                mchk(cas_lo_run >= 4, "R7 cas low", cas_lo_run, 4);
                col_cnt++;
            end
            if (rd_valid) mchk(!p_cas && cas_n, "R3 strobe with cas rise", {p_cas, cas_n}, 1);
            ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
            ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
            cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
            cas_hi_run = cas_n ? cas_hi_run + 1 : 0;
            p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_a = dram_a;
        end
    end

    task automatic do_req(input bit wr, input logic [17:0] a, input logic [7:0] d);
        int c0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        exp_row = a[17:9]; exp_col = a[8:0]; exp_wd = d;
        c0 = col_cnt;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1 chk(!req_ready, "R11 busy", req_ready, 0);
        while (col_cnt == c0) begin @(negedge clk); #1; end
        if (wr) chk(mem.exists(a) && mem[a] == d, "R4 stored byte", mem.exists(a) ? mem[a] : 0, d);
        else chk(rd_valid && rd_data == d, "R3 read data", rd_data, d);
    endtask

    initial begin
        logic       open_ok;
        logic [8:0] open_row;
        int f0, c0, k;
        open_ok = 1'b0; open_row = '0;
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid && !ref_ack,
            "R1 reset strobes", {ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid, ref_ack}, 7'b1111000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && cas_n && !dq_oe && req_ready, "R1 after reset", {ras_n, cas_n, dq_oe, req_ready}, 4'b1101);

        for (int i = 0; i < NV; i++) begin
            logic hit;
            hit = open_ok && open_row == VEC[i][25:17];
            f0 = ras_falls;
            do_req(VEC[i][26], VEC[i][25:8], VEC[i][7:0]);
            if (hit) chk(ras_falls == f0, "R5 page hit keeps row", ras_falls - f0, 0);
            else     chk(ras_falls == f0 + 1, "R6 page miss reopens", ras_falls - f0, 1);
            open_ok = 1'b1; open_row = VEC[i][25:17];
        end

        // refresh while a page is open
        @(negedge clk);
        c0 = cbr_cnt;
        ref_req = 1'b1;
        #1 chk(!req_ready, "R9 ready low on refresh", req_ready, 0);
        k = 0;
        while (!ref_ack && k < 200) begin @(negedge clk); k++; end
        chk(ref_ack && ras_n && cas_n, "R9 ack pulse", {ref_ack, ras_n, cas_n}, 3'b111);
        chk(cbr_cnt == c0 + 1, "R9 cas before ras", cbr_cnt - c0, 1);
        ref_req = 1'b0;
        @(negedge clk);
        chk(!ref_ack, "R9 ack single cycle", ref_ack, 0);
        f0 = ras_falls;
        do_req(1'b0, 18'h20000, 8'h11);
        chk(ras_falls == f0 + 1, "R9 row closed by refresh", ras_falls - f0, 1);

        // idle page closes before the page-mode limit
        do_req(1'b1, 18'h20100, 8'h5A);
        k = 0;
        while (!ras_n && k < 26000) begin @(negedge clk); k++; end
        @(negedge clk);
        chk(ras_n && last_ras_lo >= 24000 && last_ras_lo < 25000, "R8 page age close", last_ras_lo, 24991);
        f0 = ras_falls;
        do_req(1'b0, 18'h20100, 8'h5A);
        chk(ras_falls == f0 + 1, "R8 row reopened", ras_falls - f0, 1);

        repeat (20) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk + m_chk, n_err + m_err + w_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        w_err = 1;
        $display("FAIL watchdog actual=%0h expected=%0h", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk + m_chk + 1, n_err + m_err + w_err);
        $finish;
    end
endmodule